// File: doc/BRIEF.md
# Auto-Restart Protection Supervisor

This block is the supply-side supervisor of an off-line switching-regulator controller. It sequences power-up from comparator flags: while the supply capacitor charges, it keeps the high-voltage startup cell enabled and the reference off. Once the supply passes its turn-on level, it hands over to normal operation. When the supply later collapses below its turn-off level, it returns to the charging state and issues a one-cycle pulse that empties the soft-start node.

The block also watches for faults while the controller is active. A supply overvoltage counts only while soft start is still running and the feedback is above the overload level. That gated overvoltage, and a junction overtemperature flag, must each persist for a spike-blanking window before they trip the block. An overload request from the mode controller trips it at once. A trip enters auto-restart. In auto-restart the reference is off, and the startup cell follows a hysteretic loop: it stays off until the supply drops below turn-off, then recharges until turn-on. At turn-on a fresh startup phase begins.

The analog supply is not modelled. All inputs are digital comparator flags, already synchronous to the clock.

Top module: `arst_supervisor`

## Requirements
- R1: During reset and on leaving it, startup_en_o=1, ref_en_o=0, ss_discharge_o=0 and ctrl_active_o=0. The startup cell and the reference are never enabled together.
- R2: While the startup cell is enabled, a sampled vcc_above_on_i (with vcc_below_off_i low) gives, from the next cycle, ref_en_o=1, ctrl_active_o=1 and startup_en_o=0.
- R3: While active, a sampled vcc_below_off_i returns the block to charging on the next cycle (startup_en_o=1, ref_en_o=0, ctrl_active_o=0). It also raises ss_discharge_o for exactly one cycle. Undervoltage takes priority over any fault in the same cycle.
- R4: vcc_ovp_i is a fault only in cycles where ss_below_end_i and fb_over_ovl_i are both high. With either of them low, any duration of overvoltage leaves the block active.
- R5: The gated overvoltage trips the block only after OVP_BLANK consecutive active-cycle samples. It leaves on the edge of the last sample. A single low sample reloads the window.
- R6: tj_hot_i trips the block only after OTP_BLANK consecutive active-cycle samples, with the same reload rule.
- R7: While active, a sampled ovl_req_i enters auto-restart on the next cycle without blanking: all four outputs go low.
- R8: In auto-restart, ref_en_o and ctrl_active_o stay low. startup_en_o stays low, even with vcc_above_on_i high, until vcc_below_off_i is sampled. On the next cycle startup_en_o rises and ss_discharge_o pulses for one cycle.
- R9: After recharging in auto-restart, a sampled vcc_above_on_i starts a new active phase on the next cycle (ref_en_o=1, ctrl_active_o=1, startup_en_o=0).
- R10: Fault inputs are ignored while charging after reset. ovl_req_i, tj_hot_i and the gated overvoltage leave the outputs at startup_en_o=1, ref_en_o=0, ctrl_active_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on_i | input | 1 | Supply above turn-on level |
| vcc_below_off_i | input | 1 | Supply below turn-off level |
| vcc_ovp_i | input | 1 | Supply overvoltage comparator |
| tj_hot_i | input | 1 | Junction overtemperature |
| ss_below_end_i | input | 1 | Soft-start node below its end level |
| fb_over_ovl_i | input | 1 | Feedback above overload level |
| ovl_req_i | input | 1 | Overload request from the mode controller |
| startup_en_o | output | 1 | High-voltage startup cell enable |
| ref_en_o | output | 1 | Reference and bias enable |
| ss_discharge_o | output | 1 | One-cycle soft-start discharge pulse |
| ctrl_active_o | output | 1 | Controller active (switching allowed) |

## Verification
The checker assumes that vcc_above_on_i and vcc_below_off_i are never high in the same cycle. This follows from the hysteresis between the two levels. The stimulus drives them one at a time and never both.

The checker also assumes that every flag is stable around the clock edge. The bench therefore changes inputs only a few nanoseconds after an edge.

The blanking-window properties require the other fault sources to be quiet while a window is counted. The directed tests hold ovl_req_i and the competing fault low while one fault source is held for one cycle less than its window, and then for the full window.

// File: rtl/arst_pkg.sv
package arst_pkg;
   typedef enum logic [1:0] {
      ST_CHARGE  = 2'd0,
      ST_RUN     = 2'd1,
      ST_RESTART = 2'd2
   } arst_state_t;

   localparam int unsigned ARST_MAX_BLANK = 1 << 24;
   localparam int unsigned ARST_NUM_FILT  = 2;
endpackage

// File: rtl/arst_blank_filter.sv
module arst_blank_filter #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic fire_o
);
   if (CYCLES < 0 || CYCLES >= int'(arst_pkg::ARST_MAX_BLANK)) begin : g_bad_cycles
      $error("arst_blank_filter: CYCLES out of range");
   end

   if (CYCLES == 0) begin : g_bypass
      // no blanking: the qualified level trips straight away
      assign fire_o = level_i;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LOAD = CW'(CYCLES);
      localparam logic [CW-1:0] LAST = CW'(1);

      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= LOAD;
         end else if (!level_i) begin
            cnt_q <= LOAD;
         end else if (cnt_q > LAST) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign fire_o = level_i && (cnt_q == LAST);
   end
endmodule

// File: rtl/arst_fault_qual.sv
module arst_fault_qual #(
   parameter int OVP_BLANK = 1000,
   parameter int OTP_BLANK = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed_i,
   input  logic vcc_ovp_i,
   input  logic ss_below_end_i,
   input  logic fb_over_ovl_i,
   input  logic tj_hot_i,
   input  logic ovl_req_i,
   output logic trip_o
);
   localparam int NF = int'(arst_pkg::ARST_NUM_FILT);

   logic [NF-1:0] level;
   logic [NF-1:0] fire;

   // overvoltage is meaningful only during soft start with feedback out of range
   assign level[0] = armed_i && vcc_ovp_i && ss_below_end_i && fb_over_ovl_i;
   assign level[1] = armed_i && tj_hot_i;

   for (genvar g = 0; g < NF; g++) begin : g_filt
      arst_blank_filter #(
         .CYCLES((g == 0) ? OVP_BLANK : OTP_BLANK)
      ) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .level_i (level[g]),
         .fire_o  (fire[g])
      );
   end

   assign trip_o = (|fire) || (armed_i && ovl_req_i);
endmodule

// File: rtl/arst_uvlo_fsm.sv
module arst_uvlo_fsm
   import arst_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        vcc_on_i,
   input  logic        vcc_off_i,
   input  logic        trip_i,
   output arst_state_t state_o,
   output logic        recharge_o,
   output logic        discharge_o
);
   arst_state_t state_q, state_d;
   logic        recharge_q, recharge_d;
   logic        dis_q, dis_d;

   always_comb begin
      state_d    = state_q;
      recharge_d = recharge_q;
      dis_d      = 1'b0;
      unique case (state_q)
         ST_CHARGE: begin
            recharge_d = 1'b0;
            if (vcc_on_i) state_d = ST_RUN;
         end
         ST_RUN: begin
            recharge_d = 1'b0;
            if (vcc_off_i) begin
               state_d = ST_CHARGE;
               dis_d   = 1'b1;
            end else if (trip_i) begin
               state_d = ST_RESTART;
            end
         end
         ST_RESTART: begin
            if (!recharge_q) begin
               if (vcc_off_i) begin
                  recharge_d = 1'b1;
                  dis_d      = 1'b1;
               end
            end else if (vcc_on_i) begin
               state_d    = ST_RUN;
               recharge_d = 1'b0;
            end
         end
         default: begin
            state_d    = ST_CHARGE;
            recharge_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_CHARGE;
         recharge_q <= 1'b0;
         dis_q      <= 1'b0;
      end else begin
         state_q    <= state_d;
         recharge_q <= recharge_d;
         dis_q      <= dis_d;
      end
   end

   assign state_o     = state_q;
   assign recharge_o  = recharge_q;
   assign discharge_o = dis_q;
endmodule

// File: rtl/arst_supervisor.sv
module arst_supervisor
   import arst_pkg::*;
#(
   parameter int OVP_BLANK = 1000,
   parameter int OTP_BLANK = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_above_on_i,
   input  logic vcc_below_off_i,
   input  logic vcc_ovp_i,
   input  logic tj_hot_i,
   input  logic ss_below_end_i,
   input  logic fb_over_ovl_i,
   input  logic ovl_req_i,
   output logic startup_en_o,
   output logic ref_en_o,
   output logic ss_discharge_o,
   output logic ctrl_active_o
);
   arst_state_t state;
   logic        recharge;
   logic        trip;
   logic        armed;

   assign armed = (state == ST_RUN);

   arst_fault_qual #(
      .OVP_BLANK (OVP_BLANK),
      .OTP_BLANK (OTP_BLANK)
   ) u_qual (
      .clk            (clk),
      .rst_n          (rst_n),
      .armed_i        (armed),
      .vcc_ovp_i      (vcc_ovp_i),
      .ss_below_end_i (ss_below_end_i),
      .fb_over_ovl_i  (fb_over_ovl_i),
      .tj_hot_i       (tj_hot_i),
      .ovl_req_i      (ovl_req_i),
      .trip_o         (trip)
   );

   arst_uvlo_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .vcc_on_i    (vcc_above_on_i),
      .vcc_off_i   (vcc_below_off_i),
      .trip_i      (trip),
      .state_o     (state),
      .recharge_o  (recharge),
      .discharge_o (ss_discharge_o)
   );

   assign startup_en_o  = (state == ST_CHARGE) || ((state == ST_RESTART) && recharge);
   assign ref_en_o      = armed;
   assign ctrl_active_o = armed;
endmodule

// File: rtl/arst_supervisor_chk.sv
module arst_supervisor_chk #(
   parameter int OVP_BLANK = 1000,
   parameter int OTP_BLANK = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic vcc_above_on_i,
   input logic vcc_below_off_i,
   input logic vcc_ovp_i,
   input logic tj_hot_i,
   input logic ss_below_end_i,
   input logic fb_over_ovl_i,
   input logic ovl_req_i,
   input logic startup_en_o,
   input logic ref_en_o,
   input logic ss_discharge_o,
   input logic ctrl_active_o
);
   logic ovp_g;
   int   ovp_run;
   int   otp_run;

   assign ovp_g = vcc_ovp_i && ss_below_end_i && fb_over_ovl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovp_run <= 0;
         otp_run <= 0;
      end else begin
         ovp_run <= (ctrl_active_o && ovp_g && ovp_run < OVP_BLANK) ? ovp_run + 1 : 0;
         otp_run <= (ctrl_active_o && tj_hot_i && otp_run < OTP_BLANK) ? otp_run + 1 : 0;
      end
   end

   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(startup_en_o && ref_en_o));

   // R2
   turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (startup_en_o && vcc_above_on_i && !vcc_below_off_i)
      |=> (ctrl_active_o && ref_en_o && !startup_en_o));

   // R3
   undervolt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_active_o && vcc_below_off_i)
      |=> (!ctrl_active_o && startup_en_o && ss_discharge_o));

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_discharge_o |=> !ss_discharge_o);

   // R5
   ovp_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_active_o && ovp_g && !tj_hot_i && !ovl_req_i && !vcc_below_off_i
       && ovp_run < OVP_BLANK - 1) |=> ctrl_active_o);

   // R6
   otp_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_active_o && tj_hot_i && !ovp_g && !ovl_req_i && !vcc_below_off_i
       && otp_run < OTP_BLANK - 1) |=> ctrl_active_o);

   // R7
   overload_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_active_o && ovl_req_i && !vcc_below_off_i)
      |=> (!ctrl_active_o && !startup_en_o && !ref_en_o));

   // R8
   restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_en_o && !startup_en_o && !vcc_below_off_i)
      |=> (!ref_en_o && !startup_en_o));
endmodule

bind arst_supervisor arst_supervisor_chk #(
   .OVP_BLANK (OVP_BLANK),
   .OTP_BLANK (OTP_BLANK)
) u_chk (.*);

// File: tb/tb_arst_supervisor.sv
module tb_arst_supervisor;
   localparam int BLANK = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic on_i = 1'b0, off_i = 1'b0, ovp_i = 1'b0, hot_i = 1'b0;
   logic ssl_i = 1'b0, fbh_i = 1'b0, ovl_i = 1'b0;
   logic startup_en, ref_en, ss_dis, active;
   int   checks = 0;
   int   failures = 0;

   always #4 clk = ~clk;

   arst_supervisor #(.OVP_BLANK(BLANK), .OTP_BLANK(BLANK)) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .vcc_above_on_i  (on_i),
      .vcc_below_off_i (off_i),
      .vcc_ovp_i       (ovp_i),
      .tj_hot_i        (hot_i),
      .ss_below_end_i  (ssl_i),
      .fb_over_ovl_i   (fbh_i),
      .ovl_req_i       (ovl_i),
      .startup_en_o    (startup_en),
      .ref_en_o        (ref_en),
      .ss_discharge_o  (ss_dis),
      .ctrl_active_o   (active)
   );

   // row: {tag[3:0], on off ovp hot ssl fbh ovl, startup ref dis act}
   localparam logic [14:0] VEC [14] = '{
      {4'd1, 7'b0000000, 4'b1000},
      {4'd2, 7'b1000000, 4'b0101},
      {4'd2, 7'b0000000, 4'b0101},
      {4'd4, 7'b0010000, 4'b0101},
      {4'd4, 7'b0010100, 4'b0101},
      {4'd3, 7'b0100000, 4'b1010},
      {4'd3, 7'b0000000, 4'b1000},
      {4'd2, 7'b1000000, 4'b0101},
      {4'd7, 7'b0000001, 4'b0000},
      {4'd8, 7'b0000000, 4'b0000},
      {4'd8, 7'b0100000, 4'b1010},
      {4'd8, 7'b0000000, 4'b1000},
      {4'd9, 7'b1000000, 4'b0101},
      {4'd9, 7'b0000000, 4'b0101}
   };

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic drv(input logic [6:0] v);
      {on_i, off_i, ovp_i, hot_i, ssl_i, fbh_i, ovl_i} = v;
   endtask

   task automatic step(input logic [6:0] v);
      drv(v);
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input logic [3:0] exp, input string tag);
      logic [3:0] got;
      got = {startup_en, ref_en, ss_dis, active};
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b exp=%b", tag, got, exp);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(4'b1000, "R1 in reset");
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      chk(4'b1000, "R1 after reset");

      for (int i = 0; i < 14; i++) begin
         step(VEC[i][10:4]);
         chk(VEC[i][3:0], tag_name(VEC[i][14:11]));
      end

      // R4: overvoltage with feedback high but soft start finished
      for (int i = 0; i < BLANK + 5; i++) step(7'b0010010);
      chk(4'b0101, "R4 ungated ovp");

      // R5: window reload after one low sample, then full window
      for (int i = 0; i < BLANK - 1; i++) step(7'b0010110);
      chk(4'b0101, "R5 one short of window");
      step(7'b0000000);
      for (int i = 0; i < BLANK - 1; i++) step(7'b0010110);
      chk(4'b0101, "R5 window reloaded");
      step(7'b0010110);
      chk(4'b0000, "R5 window expired");
      step(7'b0100000);
      chk(4'b1010, "R8 recharge after ovp");
      step(7'b1000000);
      chk(4'b0101, "R9 restart after ovp");

      // R6: temperature blanking
      for (int i = 0; i < BLANK - 1; i++) step(7'b0001000);
      chk(4'b0101, "R6 one short of window");
      step(7'b0001000);
      chk(4'b0000, "R6 window expired");

      // R8: turn-on flag ignored before recharge
      for (int i = 0; i < 5; i++) step(7'b1000000);
      chk(4'b0000, "R8 above_on ignored");
      step(7'b0100000);
      chk(4'b1010, "R8 discharge pulse");
      step(7'b0000000);
      chk(4'b1000, "R8 pulse single cycle");
      step(7'b1000000);
      chk(4'b0101, "R9 new startup");

      // R1: reset from active
      drv(7'b0000000);
      #1;
      rst_n = 1'b0;
      #1;
      chk(4'b1000, "R1 reset from run");
      @(posedge clk);
      #2;
      rst_n = 1'b1;

      // R10: faults ignored while charging
      for (int i = 0; i < BLANK + 5; i++) step(7'b0011111);
      chk(4'b1000, "R10 faults ignored in charge");
      step(7'b1000000);
      chk(4'b0101, "R10 turn-on after ignored faults");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule